// File: doc/BRIEF.md
# Folded 64-Point Inverse FFT Engine

This block turns one frame of 64 complex frequency-domain samples into 64 complex time-domain samples. It uses a single radix-4 butterfly node and runs it 48 times per frame: three radix-4 stages of sixteen groups each. A stage counter and a group counter select which four entries of a 64-entry working array feed the node, and which twiddle constants are applied. They also select where the four results are written back. At the end of each stage the whole array is rewired by a fixed stride reordering. After the third stage the output appears in natural time order.

The frame is transferred in parallel over a valid/ready pair on each side. Sample `p` occupies bits `[32p+31:32p]`: the real part is in the upper 16 bits and the imaginary part in the lower 16 bits. Both parts are signed Q1.15. The engine takes its input in base-4 digit-reversed order. Position `p = 16a + 4b + c` carries frequency bin `rev4(p) = 16c + 4b + a`. Twiddles are held with 17 bits, so that a unity factor is exact. Each complex product is shifted right arithmetically by 15, and every add or subtract wraps in 16 bits.

Top module: `ifft_fold64`

## Requirements
- R1: After a synchronous active-low reset, `in_ready` is 1, `out_valid` is 0 and every bit of `out_frame` is 0.
- R2: A frame is taken on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle `in_ready` is 0 until the result has been handed over.
- R3: `out_valid` first reads 1 after the 48th rising edge that follows the accepting edge, one edge for each butterfly step.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_frame` does not change. One edge with `out_ready` high clears `out_valid` and sets `in_ready`.
- R5: For input components within ±250, output position `k` lies within 16 LSB of the real value `sum over p of in[p]·exp(+j·2π·k·rev4(p)/64)`. This holds for the real and the imaginary part.
- R6: A frame whose only nonzero sample is at position 0 gives that same sample, bit for bit, at all 64 output positions.
- R7: Output position 0 equals, bit for bit, the 16-bit wrapped sum of all 64 inputs, separately for the real and the imaginary part. This holds even when the sum overflows.
- R8: `in_valid` and `in_frame` activity while a frame is in progress or waiting for `out_ready` is ignored. It does not change the result being computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input frame is present |
| in_ready | output | 1 | Engine is idle and will take a frame |
| in_frame | input | 2048 | 64 packed complex inputs, digit-reversed order |
| out_valid | output | 1 | Result frame is present |
| out_ready | input | 1 | Consumer takes the result |
| out_frame | output | 2048 | 64 packed complex outputs, natural order |

## Verification
The assertions assume that reset is applied before the first frame. They also assume that `out_ready` is only meaningful while `out_valid` is high. They do not assume anything about the numeric range of the samples. The bench keeps every component of the checked frames within ±250, so that no intermediate value wraps and the real-valued reference stays comparable. A single dedicated frame drives the sums past 16 bits, and on that frame only output position 0 is compared. The bench also keeps `in_valid` high with altered data while a frame is in flight and while a result is held back by `out_ready`. That shows that such input is ignored.

// File: rtl/ifft_fold_pkg.sv
// Shared sizes, sample types and the inter-stage reordering for the folded
// radix-4 inverse FFT. Assumes three radix-4 stages (64 points).
package ifft_fold_pkg;
    localparam int SAMP_W  = 16;
    localparam int TWID_W  = SAMP_W + 1;
    localparam int FRAC_W  = SAMP_W - 1;
    localparam int RADIX   = 4;
    localparam int NSTAGE  = 3;
    localparam int NPTS    = RADIX ** NSTAGE;
    localparam int NGRP    = NPTS / RADIX;
    localparam int GRP_W   = $clog2(NGRP);
    localparam int STG_W   = $clog2(NSTAGE);
    localparam int LANE_W  = $clog2(RADIX);
    localparam int PHASE_W = $clog2(NPTS);
    localparam int CPLX_W  = 2 * SAMP_W;
    localparam int FRAME_W = NPTS * CPLX_W;

    typedef struct packed {
        logic signed [SAMP_W-1:0] re;
        logic signed [SAMP_W-1:0] im;
    } cplx_t;

    typedef struct packed {
        logic signed [TWID_W-1:0] re;
        logic signed [TWID_W-1:0] im;
    } twid_t;

    // Source entry for reordered position i: lowest digit of the source moves to the top.
    function automatic int perm_src(input int i);
        return (i % NGRP) * RADIX + i / NGRP;
    endfunction
endpackage

// File: rtl/ifft_twiddle.sv
// Twiddle generator: maps (stage, group) to four unit-circle constants
// exp(+j*2*pi*e/64). Stage 0 uses e=0, stage 1 uses e=4*r*(grp/4), and
// stage 2 uses e=r*grp, for lane r. Values are scaled by 2^15 in 17 bits.
module ifft_twiddle
    import ifft_fold_pkg::*;
(
    input  logic [STG_W-1:0] stage_i,
    input  logic [GRP_W-1:0] grp_i,
    output twid_t            tw_o [RADIX]
);
    localparam int QTR = NPTS / 4;

    // Quarter-wave sine, sin(pi*f/32) scaled by 32768, f = 0..16.
    function automatic int qsine(input int f);
        case (f)
            0:  return 0;
            1:  return 3212;
            2:  return 6393;
            3:  return 9512;
            4:  return 12540;
            5:  return 15447;
            6:  return 18205;
            7:  return 20788;
            8:  return 23170;
            9:  return 25330;
            10: return 27246;
            11: return 28899;
            12: return 30274;
            13: return 31357;
            14: return 32138;
            15: return 32610;
            16: return 32768;
            default: return 0;
        endcase
    endfunction

    for (genvar r = 0; r < RADIX; r++) begin : g_lane
        logic [PHASE_W-1:0]       ph;
        logic [PHASE_W-3:0]       fine;
        logic [1:0]               quad;
        logic signed [TWID_W-1:0] s_f, s_c, lre, lim;

        // Phase index for this lane from stage and group.
        always_comb begin
            case (stage_i)
                STG_W'(1): ph = PHASE_W'(RADIX * r) * PHASE_W'(grp_i[GRP_W-1 -: LANE_W]);
                STG_W'(2): ph = PHASE_W'(r) * PHASE_W'(grp_i);
                default:   ph = '0;
            endcase
        end

        assign quad = ph[PHASE_W-1 -: 2];
        assign fine = ph[PHASE_W-3:0];
        assign s_f  = TWID_W'(qsine(int'(fine)));
        assign s_c  = TWID_W'(qsine(QTR - int'(fine)));

        // Quadrant folding of the quarter-wave table into cosine and sine.
        always_comb begin
            case (quad)
                2'd0:    begin lre =  s_c; lim =  s_f; end
                2'd1:    begin lre = -s_f; lim =  s_c; end
                2'd2:    begin lre = -s_c; lim = -s_f; end
                default: begin lre =  s_f; lim = -s_c; end
            endcase
        end

        assign tw_o[r] = {lre, lim};

        // The first stage must apply an exact unity factor on every lane.
        always_comb begin
            if (stage_i == '0) begin
                a_r6_unity_first_stage: assert (lre == (TWID_W'(1) <<< FRAC_W) && lim == '0);
            end
        end
    end
endmodule

// File: rtl/ifft_bfly4.sv
// Radix-4 butterfly node: pre-multiplies four operands by four twiddles,
// then forms the inverse 4-point DFT. Combinational; assumes Q1.15 samples
// and 17-bit twiddles; products are shifted right by 15 and all sums wrap.
module ifft_bfly4
    import ifft_fold_pkg::*;
(
    input  cplx_t x_i [RADIX],
    input  twid_t w_i [RADIX],
    output cplx_t y_o [RADIX]
);
    localparam int ACC_W = SAMP_W + TWID_W + 1;

    // Complex product rounded down to 16 bits by an arithmetic shift.
    function automatic cplx_t cmul(input cplx_t x, input twid_t w);
        logic signed [ACC_W-1:0] pr, pi;
        cplx_t z;
        pr = ACC_W'(x.re) * ACC_W'(w.re) - ACC_W'(x.im) * ACC_W'(w.im);
        pi = ACC_W'(x.re) * ACC_W'(w.im) + ACC_W'(x.im) * ACC_W'(w.re);
        z.re = SAMP_W'(pr >>> FRAC_W);
        z.im = SAMP_W'(pi >>> FRAC_W);
        return z;
    endfunction

    cplx_t m [RADIX];
    cplx_t sa, sb, sc, sd, st;

    // Twiddle products followed by the two add/subtract layers.
    always_comb begin
        for (int r = 0; r < RADIX; r++) m[r] = cmul(x_i[r], w_i[r]);
        sa.re = m[0].re + m[2].re;  sa.im = m[0].im + m[2].im;
        sb.re = m[0].re - m[2].re;  sb.im = m[0].im - m[2].im;
        sc.re = m[1].re + m[3].re;  sc.im = m[1].im + m[3].im;
        st.re = m[1].re - m[3].re;  st.im = m[1].im - m[3].im;
        sd.re = -st.im;             sd.im = st.re;
        y_o[0].re = sa.re + sc.re;  y_o[0].im = sa.im + sc.im;
        y_o[1].re = sb.re + sd.re;  y_o[1].im = sb.im + sd.im;
        y_o[2].re = sa.re - sc.re;  y_o[2].im = sa.im - sc.im;
        y_o[3].re = sb.re - sd.re;  y_o[3].im = sb.im - sd.im;
    end
endmodule

// File: rtl/ifft_seq.sv
// Sequencer: idle / running / holding-result states, with the stage counter
// (0..2) and group counter (0..15) that steer the shared butterfly.
// Assumes the data path applies the reordering when stage_end_o is high.
module ifft_seq
    import ifft_fold_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             load_o,
    output logic             step_o,
    output logic             stage_end_o,
    output logic [STG_W-1:0] stage_o,
    output logic [GRP_W-1:0] grp_o
);
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} seq_state_t;

    localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(NGRP - 1);
    localparam logic [STG_W-1:0] STG_LAST = STG_W'(NSTAGE - 1);

    seq_state_t       state_q;
    logic [STG_W-1:0] stage_q;
    logic [GRP_W-1:0] grp_q;

    assign in_ready    = (state_q == S_IDLE);
    assign out_valid   = (state_q == S_HOLD);
    assign load_o      = in_ready && in_valid;
    assign step_o      = (state_q == S_RUN);
    assign stage_end_o = step_o && (grp_q == GRP_LAST);
    assign stage_o     = stage_q;
    assign grp_o       = grp_q;

    // State and counter update per butterfly step and handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            stage_q <= '0;
            grp_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (in_valid) begin
                    state_q <= S_RUN;
                    stage_q <= '0;
                    grp_q   <= '0;
                end
                S_RUN: begin
                    if (grp_q == GRP_LAST) begin
                        grp_q <= '0;
                        if (stage_q == STG_LAST) begin
                            state_q <= S_HOLD;
                            stage_q <= '0;
                        end else begin
                            stage_q <= stage_q + 1'b1;
                        end
                    end else begin
                        grp_q <= grp_q + 1'b1;
                    end
                end
                default: if (out_ready) state_q <= S_IDLE;
            endcase
        end
    end

    a_r1_ready_valid_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && stage_o == '0 && grp_o == '0));

    a_r3_group_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && grp_o != GRP_LAST)
        |=> (grp_o == GRP_W'($past(grp_o) + 1'b1) && stage_o == $past(stage_o) && step_o));

    a_r3_stage_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && grp_o == GRP_LAST && stage_o != STG_LAST)
        |=> (grp_o == '0 && stage_o == STG_W'($past(stage_o) + 1'b1) && step_o));

    a_r3_result_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(step_o && grp_o == GRP_LAST && stage_o == STG_LAST));

    a_r4_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (in_ready && !out_valid));
endmodule

// File: rtl/ifft_fold64.sv
// Folded 64-point inverse FFT top: working array of 64 complex entries,
// group operand selectors, write-back steering and the end-of-stage
// reordering around one shared radix-4 butterfly. Input is taken in base-4
// digit-reversed order; output is in natural order.
module ifft_fold64
    import ifft_fold_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [FRAME_W-1:0] in_frame,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [FRAME_W-1:0] out_frame
);
    logic             load, step, stage_end;
    logic [STG_W-1:0] stage;
    logic [GRP_W-1:0] grp;

    cplx_t work [NPTS];
    cplx_t upd  [NPTS];
    cplx_t opnd [RADIX];
    cplx_t res  [RADIX];
    twid_t twid [RADIX];

    ifft_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .out_ready   (out_ready),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .load_o      (load),
        .step_o      (step),
        .stage_end_o (stage_end),
        .stage_o     (stage),
        .grp_o       (grp)
    );

    ifft_twiddle u_twiddle (
        .stage_i (stage),
        .grp_i   (grp),
        .tw_o    (twid)
    );

    ifft_bfly4 u_bfly (
        .x_i (opnd),
        .w_i (twid),
        .y_o (res)
    );

    // Group operand selectors driven by the group counter.
    for (genvar r = 0; r < RADIX; r++) begin : g_opnd
        assign opnd[r] = work[{grp, LANE_W'(r)}];
    end

    // Write-back decode: the current group replaced by the butterfly results.
    always_comb begin
        for (int j = 0; j < NPTS; j++) upd[j] = work[j];
        for (int r = 0; r < RADIX; r++) upd[{grp, LANE_W'(r)}] = res[r];
    end

    for (genvar i = 0; i < NPTS; i++) begin : g_ent
        localparam int SRC = perm_src(i);
        cplx_t ent_q;

        // One entry: frame load, in-place write-back, or end-of-stage reorder.
        always_ff @(posedge clk) begin
            if (!rst_n)      ent_q <= '0;
            else if (load)   ent_q <= in_frame[i*CPLX_W +: CPLX_W];
            else if (step)   ent_q <= stage_end ? upd[SRC] : upd[i];
        end

        assign work[i] = ent_q;
        assign out_frame[i*CPLX_W +: CPLX_W] = ent_q;
    end

    a_r4_frame_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_frame));

    a_r8_no_reload_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !step && !out_ready) |=> $stable(out_frame));
endmodule

// File: tb/test_ifft_fold64.sv
// Bench: drives frames, compares against a real-valued inverse DFT and
// exact fixed-point identities, and checks handshake timing.
module test_ifft_fold64;
    import ifft_fold_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic               in_ready;
    logic [FRAME_W-1:0] in_frame;
    logic               out_valid;
    logic               out_ready;
    logic [FRAME_W-1:0] out_frame;

    always #10 clk = ~clk;

    ifft_fold64 i_ifft_fold64 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_frame  (in_frame),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_frame (out_frame)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int unsigned seed = 32'h1234_5678;
    logic signed [15:0] fr_re [64];
    logic signed [15:0] fr_im [64];
    localparam real PI = 3.14159265358979;
    localparam real TOL = 16.0;

    task automatic chk(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic int rev4(input int p);
        return (p % 4) * 16 + ((p / 4) % 4) * 4 + p / 16;
    endfunction

    function automatic int rnd250();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return int'(seed % 501) - 250;
    endfunction

    task automatic fill_zero();
        for (int p = 0; p < 64; p++) begin fr_re[p] = '0; fr_im[p] = '0; end
    endtask

    task automatic fill_random();
        for (int p = 0; p < 64; p++) begin
            fr_re[p] = 16'(rnd250());
            fr_im[p] = 16'(rnd250());
        end
    endtask

    task automatic run_frame(input string name, input bit tol_chk, input bit dc_chk,
                             input bit junk, input int hold);
        logic [FRAME_W-1:0] snap;
        logic signed [15:0] sr, si, ar, ai;
        int  n;
        int  bad_before;
        real er, ei, th, dr, di;

        @(negedge clk);
        for (int p = 0; p < 64; p++) in_frame[p*32 +: 32] = {fr_re[p], fr_im[p]};
        in_valid = 1'b1;
        chk(in_ready == 1'b1, $sformatf("R2 %s in_ready before accept act=%0b exp=1", name, in_ready));
        @(posedge clk);
        @(negedge clk);
        chk(in_ready == 1'b0, $sformatf("R2 %s in_ready after accept act=%0b exp=0", name, in_ready));
        bad_before = n_bad;
        if (junk) in_frame = ~in_frame;
        else      in_valid = 1'b0;

        n = 0;
        while (!out_valid && n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        chk(n == 48, $sformatf("R3 %s latency act=%0d exp=48", name, n));

        snap = out_frame;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(out_valid && out_frame == snap,
                $sformatf("R4 %s hold cycle %0d valid act=%0b exp=1 stable act=%0b exp=1",
                          name, h, out_valid, out_frame == snap));
            if (junk) chk(in_ready == 1'b0,
                $sformatf("R8 %s in_ready while holding act=%0b exp=0", name, in_ready));
        end

        // R7: position 0 is the wrapped 16-bit sum of all inputs.
        sr = '0; si = '0;
        for (int p = 0; p < 64; p++) begin sr += fr_re[p]; si += fr_im[p]; end
        ar = out_frame[16 +: 16];
        ai = out_frame[0 +: 16];
        chk(ar == sr && ai == si,
            $sformatf("R7 %s out[0] act=(%0d,%0d) exp=(%0d,%0d)", name, ar, ai, sr, si));

        if (dc_chk) begin
            for (int k = 0; k < 64; k++) begin
                ar = out_frame[k*32+16 +: 16];
                ai = out_frame[k*32 +: 16];
                chk(ar == fr_re[0] && ai == fr_im[0],
                    $sformatf("R6 %s out[%0d] act=(%0d,%0d) exp=(%0d,%0d)",
                              name, k, ar, ai, fr_re[0], fr_im[0]));
            end
        end

        if (tol_chk) begin
            for (int k = 0; k < 64; k++) begin
                er = 0.0; ei = 0.0;
                for (int p = 0; p < 64; p++) begin
                    th = 2.0 * PI * $itor(k * rev4(p)) / 64.0;
                    er += $itor(fr_re[p]) * $cos(th) - $itor(fr_im[p]) * $sin(th);
                    ei += $itor(fr_re[p]) * $sin(th) + $itor(fr_im[p]) * $cos(th);
                end
                ar = out_frame[k*32+16 +: 16];
                ai = out_frame[k*32 +: 16];
                dr = $itor(ar) - er; if (dr < 0.0) dr = -dr;
                di = $itor(ai) - ei; if (di < 0.0) di = -di;
                chk(dr <= TOL && di <= TOL,
                    $sformatf("R5 %s out[%0d] act=(%0d,%0d) exp=(%0.1f,%0.1f)",
                              name, k, ar, ai, er, ei));
            end
        end

        if (junk) chk(n_bad == bad_before,
            $sformatf("R8 %s result with busy input activity act=%0d mismatches exp=0",
                      name, n_bad - bad_before));

        in_valid  = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        chk(!out_valid && in_ready,
            $sformatf("R4 %s release act=(valid %0b, ready %0b) exp=(0,1)", name, out_valid, in_ready));
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_frame = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0 && out_frame == '0,
            $sformatf("R1 reset state act=(ready %0b, valid %0b) exp=(1,0)", in_ready, out_valid));

        fill_zero();
        fr_re[0] = 16'sd12000; fr_im[0] = -16'sd7000;
        run_frame("dc", 1'b1, 1'b1, 1'b0, 2);

        fill_zero();
        fr_re[16] = 16'sd250; fr_im[16] = -16'sd120;
        run_frame("bin1", 1'b1, 1'b0, 1'b0, 0);

        fill_random();
        run_frame("randA", 1'b1, 1'b0, 1'b0, 3);

        fill_random();
        run_frame("randB_busy", 1'b1, 1'b0, 1'b1, 5);

        fill_random();
        run_frame("randC", 1'b1, 1'b0, 1'b0, 0);

        fill_zero();
        fr_re[37] = -16'sd200; fr_im[37] = 16'sd180;
        run_frame("pos37", 1'b1, 1'b0, 1'b0, 1);

        for (int p = 0; p < 64; p++) begin fr_re[p] = 16'sd1000; fr_im[p] = -16'sd1000; end
        run_frame("wrap", 1'b0, 1'b0, 1'b0, 0);

        fill_random();
        run_frame("randD", 1'b1, 1'b0, 1'b1, 2);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule